// File: doc/BRIEF.md
# Asynchronous Split-Transaction Sequencer

This block is the per-queue-head controller that moves a full-speed or low-speed control or bulk transfer over a high-speed link by way of a hub's transaction translator. It holds two pieces of state: which split phase comes next (start or complete), and a small error budget that counts down.

On each scheduling slot it offers one split request. The request names the phase, the hub address, the translator port and the endpoint-type code. The handshake outcome comes back as decoded strobes. The block then updates its phase, its error budget, a halt flag and a sticky transaction-error flag. A clean completion of the complete phase raises a one-cycle done pulse.

Software loads the configuration inputs and pulses `cfg_init` to start or restart the endpoint. A halted endpoint stays quiet until that pulse arrives.

Top module: `async_split_seq`

## Requirements
- R1: After reset, and in the cycle after a `cfg_init` pulse, `split_phase` is 0 (start), `halted` and `xact_err` are 0, and `err_cnt` holds the budget. The budget is the parameter CERR_RESET (default 3) after reset and `cfg_cerr` after init. `cfg_init` overrides any handshake strobe in the same cycle.
- R2: Splits are used only when `cfg_speed` is 2'b00 (full speed) or 2'b01 (low speed). In that case `req_valid` follows `slot_go` while the endpoint is not halted. With `cfg_speed` 2'b10 (high speed), `req_valid` stays 0 and handshake strobes change nothing.
- R3: `req_hub` and `req_port` carry `cfg_hub` and `cfg_port`. `req_ept` is 2'b00 (control) when `cfg_ctrl` is 1 and 2'b10 (bulk) when it is 0. `req_kind` is 0 for a start-split and 1 for a complete-split, and it equals `split_phase`.
- R4: In the start phase, ACK moves to the complete phase. NAK keeps the start phase, leaves the budget unchanged and does not halt. NYET and STALL are ignored in the start phase.
- R5: A transaction-error strobe in either phase decrements a nonzero `err_cnt` by one. When the count reaches 0 this way, `halted` becomes 1.
- R6: When the budget is 0, a transaction error leaves `err_cnt` at 0 and never halts the endpoint.
- R7: In the complete phase, NYET keeps the complete phase so the complete-split is retried at once. The budget is unchanged and nothing is halted.
- R8: In the complete phase, STALL sets `halted`.
- R9: In the complete phase, a transaction error sets `xact_err` and keeps the complete phase. `xact_err` stays set until `cfg_init`.
- R10: In the complete phase, an ACK with no error, NYET or STALL returns to the start phase and raises `done` for exactly one cycle. A NAK in the complete phase returns to the start phase without `done`.
- R11: While `halted` is 1, `req_valid` is 0 and all handshake strobes are ignored until `cfg_init`.
- R12: When several strobes arrive together, exactly one is applied, in this priority order: transaction error, then STALL, then NYET, then NAK, then ACK.
- R13: The effect of a strobe sampled at a clock edge is visible on the outputs after that edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_init | input | 1 | Software (re)initialization pulse |
| cfg_speed | input | 2 | Endpoint speed: 00 full, 01 low, 10 high |
| cfg_ctrl | input | 1 | 1 = control endpoint, 0 = bulk |
| cfg_hub | input | HUB_W | Hub device address |
| cfg_port | input | PORT_W | Translator port number |
| cfg_cerr | input | CERR_W | Error budget loaded on init |
| slot_go | input | 1 | Scheduling slot offered to this queue head |
| rsp_ack | input | 1 | ACK (or data) received |
| rsp_nak | input | 1 | NAK received |
| rsp_nyet | input | 1 | NYET received |
| rsp_stall | input | 1 | STALL received |
| rsp_xerr | input | 1 | Transaction error |
| req_valid | output | 1 | Split request issued this slot |
| req_kind | output | 1 | 0 start-split, 1 complete-split |
| req_hub | output | HUB_W | Hub address field |
| req_port | output | PORT_W | Port field |
| req_ept | output | 2 | Endpoint-type field |
| split_phase | output | 1 | Current split phase |
| err_cnt | output | CERR_W | Remaining error budget |
| halted | output | 1 | Endpoint halted |
| xact_err | output | 1 | Sticky transaction-error flag |
| done | output | 1 | One-cycle clean-completion pulse |

## Verification
Two events can collide in one cycle. The first case is a transaction error in the complete phase when the budget is 1: the sticky error flag sets and the endpoint halts together. The bench provokes this by loading a budget of 1, moving to the complete phase and then raising the error strobe. It judges the result by seeing `xact_err`, `halted` and a zero `err_cnt` all appear after the same edge. The bench also raises competing strobes together (error with ACK, STALL with NYET, NYET with ACK) and checks that only the higher-priority outcome shows on phase, budget, halt and done.

// File: rtl/split_seq_pkg.sv
package split_seq_pkg;

   typedef enum logic {
      PH_START    = 1'b0,
      PH_COMPLETE = 1'b1
   } phase_e;

   typedef enum logic [2:0] {
      EV_NONE  = 3'd0,
      EV_XERR  = 3'd1,
      EV_STALL = 3'd2,
      EV_NYET  = 3'd3,
      EV_NAK   = 3'd4,
      EV_ACK   = 3'd5
   } evt_e;

   localparam logic [1:0] SPD_FULL = 2'b00;
   localparam logic [1:0] SPD_LOW  = 2'b01;
   localparam logic [1:0] SPD_HIGH = 2'b10;

   localparam logic [1:0] ET_CTRL  = 2'b00;
   localparam logic [1:0] ET_BULK  = 2'b10;

   // Strongest outcome wins when strobes coincide.
   function automatic evt_e pick_event(input logic ack, input logic nak,
                                       input logic nyet, input logic stall,
                                       input logic xerr);
      if (xerr)       return EV_XERR;
      else if (stall) return EV_STALL;
      else if (nyet)  return EV_NYET;
      else if (nak)   return EV_NAK;
      else if (ack)   return EV_ACK;
      else            return EV_NONE;
   endfunction

endpackage

// File: rtl/split_err_budget.sv
module split_err_budget #(
   parameter int CERR_W     = 2,
   parameter int CERR_RESET = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CERR_W-1:0] load_val,
   input  logic              dec,
   output logic [CERR_W-1:0] cnt,
   output logic              hit_zero
);
   localparam logic [CERR_W-1:0] RST_VAL = CERR_W'(CERR_RESET);
   localparam logic [CERR_W-1:0] ONE     = CERR_W'(1);

   logic [CERR_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= RST_VAL;
      else if (load)
         cnt_q <= load_val;
      else if (dec && (cnt_q != '0))
         cnt_q <= cnt_q - ONE;
   end

   assign cnt      = cnt_q;
   assign hit_zero = dec && !load && (cnt_q == ONE);
endmodule

// File: rtl/split_phase_fsm.sv
module split_phase_fsm
   import split_seq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   init,
   input  logic   active,
   input  evt_e   evt,
   input  logic   budget_out,
   output phase_e phase,
   output logic   halted,
   output logic   xact_err,
   output logic   done
);
   phase_e phase_q;
   logic   halt_q, xerr_q, done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_START;
         halt_q  <= 1'b0;
         xerr_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (init) begin
            phase_q <= PH_START;
            halt_q  <= 1'b0;
            xerr_q  <= 1'b0;
         end else if (active) begin
            unique case (phase_q)
               PH_START: begin
                  if (evt == EV_ACK)
                     phase_q <= PH_COMPLETE;
                  else if ((evt == EV_XERR) && budget_out)
                     halt_q <= 1'b1;
               end
               PH_COMPLETE: begin
                  unique case (evt)
                     EV_XERR: begin
                        xerr_q <= 1'b1;
                        if (budget_out) halt_q <= 1'b1;
                     end
                     EV_STALL: halt_q  <= 1'b1;
                     EV_NAK:   phase_q <= PH_START;
                     EV_ACK: begin
                        phase_q <= PH_START;
                        done_q  <= 1'b1;
                     end
                     default: ;
                  endcase
               end
               default: phase_q <= PH_START;
            endcase
         end
      end
   end

   assign phase    = phase_q;
   assign halted   = halt_q;
   assign xact_err = xerr_q;
   assign done     = done_q;
endmodule

// File: rtl/split_token_fmt.sv
module split_token_fmt
   import split_seq_pkg::*;
#(
   parameter int HUB_W  = 7,
   parameter int PORT_W = 7
) (
   input  logic              slot_go,
   input  logic              enable,
   input  phase_e            phase,
   input  logic              ctrl,
   input  logic [HUB_W-1:0]  hub,
   input  logic [PORT_W-1:0] port,
   output logic              valid,
   output logic              kind,
   output logic [HUB_W-1:0]  tok_hub,
   output logic [PORT_W-1:0] tok_port,
   output logic [1:0]        tok_ept
);
   assign valid    = slot_go && enable;
   assign kind     = (phase == PH_COMPLETE);
   assign tok_hub  = hub;
   assign tok_port = port;
   assign tok_ept  = ctrl ? ET_CTRL : ET_BULK;
endmodule

// File: rtl/async_split_seq.sv
module async_split_seq
   import split_seq_pkg::*;
#(
   parameter int HUB_W      = 7,
   parameter int PORT_W     = 7,
   parameter int CERR_W     = 2,
   parameter int CERR_RESET = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_init,
   input  logic [1:0]        cfg_speed,
   input  logic              cfg_ctrl,
   input  logic [HUB_W-1:0]  cfg_hub,
   input  logic [PORT_W-1:0] cfg_port,
   input  logic [CERR_W-1:0] cfg_cerr,
   input  logic              slot_go,
   input  logic              rsp_ack,
   input  logic              rsp_nak,
   input  logic              rsp_nyet,
   input  logic              rsp_stall,
   input  logic              rsp_xerr,
   output logic              req_valid,
   output logic              req_kind,
   output logic [HUB_W-1:0]  req_hub,
   output logic [PORT_W-1:0] req_port,
   output logic [1:0]        req_ept,
   output logic              split_phase,
   output logic [CERR_W-1:0] err_cnt,
   output logic              halted,
   output logic              xact_err,
   output logic              done
);
   localparam int CERR_MAX = (1 << CERR_W) - 1;

   generate
      if (HUB_W < 1 || PORT_W < 1)
         $error("address and port widths must be at least one bit");
      if (CERR_W < 1 || CERR_W > 8)
         $error("error budget width out of range");
      if (CERR_RESET < 0 || CERR_RESET > CERR_MAX)
         $error("reset budget does not fit the counter");
   endgenerate

   logic   split_en, active, budget_out;
   evt_e   evt;
   phase_e phase;

   assign split_en = (cfg_speed == SPD_FULL) || (cfg_speed == SPD_LOW);
   assign active   = split_en && !halted;
   assign evt      = pick_event(rsp_ack, rsp_nak, rsp_nyet, rsp_stall, rsp_xerr);

   split_err_budget #(.CERR_W(CERR_W), .CERR_RESET(CERR_RESET)) u_budget (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_init),
      .load_val (cfg_cerr),
      .dec      (active && (evt == EV_XERR)),
      .cnt      (err_cnt),
      .hit_zero (budget_out)
   );

   split_phase_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .init       (cfg_init),
      .active     (active),
      .evt        (evt),
      .budget_out (budget_out),
      .phase      (phase),
      .halted     (halted),
      .xact_err   (xact_err),
      .done       (done)
   );

   split_token_fmt #(.HUB_W(HUB_W), .PORT_W(PORT_W)) u_tok (
      .slot_go  (slot_go),
      .enable   (active),
      .phase    (phase),
      .ctrl     (cfg_ctrl),
      .hub      (cfg_hub),
      .port     (cfg_port),
      .valid    (req_valid),
      .kind     (req_kind),
      .tok_hub  (req_hub),
      .tok_port (req_port),
      .tok_ept  (req_ept)
   );

   assign split_phase = phase;
endmodule

// File: rtl/async_split_seq_chk.sv
module async_split_seq_chk #(
   parameter int CERR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_init,
   input logic [1:0]        cfg_speed,
   input logic              rsp_ack,
   input logic              rsp_xerr,
   input logic              rsp_stall,
   input logic              req_valid,
   input logic              split_phase,
   input logic [CERR_W-1:0] err_cnt,
   input logic              halted,
   input logic              xact_err,
   input logic              done
);
   logic sp_on;
   assign sp_on = (cfg_speed == 2'b00) || (cfg_speed == 2'b01);

   // R11
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !req_valid);

   // R2
   hs_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_speed == 2'b10) |-> !req_valid);

   // R4
   start_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_on && !halted && !cfg_init && !split_phase && rsp_ack && !rsp_xerr)
      |=> split_phase);

   // R8
   cmp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_on && !halted && !cfg_init && split_phase && rsp_stall) |=> halted);

   // R9
   xerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xact_err && !cfg_init) |=> xact_err);

   // R10
   done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!split_phase && !halted));

   // R10
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   budget_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_init |=> (err_cnt <= $past(err_cnt)));
endmodule

bind async_split_seq async_split_seq_chk #(.CERR_W(CERR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_init    (cfg_init),
   .cfg_speed   (cfg_speed),
   .rsp_ack     (rsp_ack),
   .rsp_xerr    (rsp_xerr),
   .rsp_stall   (rsp_stall),
   .req_valid   (req_valid),
   .split_phase (split_phase),
   .err_cnt     (err_cnt),
   .halted      (halted),
   .xact_err    (xact_err),
   .done        (done)
);

// File: tb/async_split_seq_test.sv
module async_split_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_init = 1'b0;
   logic [1:0] cfg_speed = 2'b00;
   logic       cfg_ctrl = 1'b1;
   logic [6:0] cfg_hub = 7'h2A;
   logic [6:0] cfg_port = 7'h05;
   logic [1:0] cfg_cerr = 2'd3;
   logic       slot_go = 1'b0;
   logic       rsp_ack = 0, rsp_nak = 0, rsp_nyet = 0, rsp_stall = 0, rsp_xerr = 0;
   logic       req_valid, req_kind, split_phase, halted, xact_err, done;
   logic [6:0] req_hub, req_port;
   logic [1:0] req_ept, err_cnt;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   async_split_seq uut (
      .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_speed(cfg_speed),
      .cfg_ctrl(cfg_ctrl), .cfg_hub(cfg_hub), .cfg_port(cfg_port),
      .cfg_cerr(cfg_cerr), .slot_go(slot_go), .rsp_ack(rsp_ack),
      .rsp_nak(rsp_nak), .rsp_nyet(rsp_nyet), .rsp_stall(rsp_stall),
      .rsp_xerr(rsp_xerr), .req_valid(req_valid), .req_kind(req_kind),
      .req_hub(req_hub), .req_port(req_port), .req_ept(req_ept),
      .split_phase(split_phase), .err_cnt(err_cnt), .halted(halted),
      .xact_err(xact_err), .done(done)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic state(input string tag, input int ph, input int cnt,
                        input int hlt, input int xe);
      chk({tag, " phase"}, split_phase, ph);
      chk({tag, " err_cnt"}, err_cnt, cnt);
      chk({tag, " halted"}, halted, hlt);
      chk({tag, " xact_err"}, xact_err, xe);
   endtask

   // strobes held over one rising edge; returns at the following falling edge
   task automatic hs(input bit a, input bit n, input bit y, input bit s, input bit x);
      @(negedge clk);
      {rsp_ack, rsp_nak, rsp_nyet, rsp_stall, rsp_xerr} = {a, n, y, s, x};
      @(negedge clk);
      {rsp_ack, rsp_nak, rsp_nyet, rsp_stall, rsp_xerr} = '0;
   endtask

   task automatic init(input logic [1:0] budget);
      @(negedge clk);
      cfg_cerr = budget;
      cfg_init = 1'b1;
      @(negedge clk);
      cfg_init = 1'b0;
   endtask

   task automatic t_reset;
      state("R1 reset", 0, 3, 0, 0);
      chk("R1 reset done", done, 0);
   endtask

   task automatic t_request;
      @(negedge clk);
      slot_go = 1'b1; cfg_speed = 2'b00; cfg_ctrl = 1'b1;
      #1;
      chk("R2 full-speed req_valid", req_valid, 1);
      chk("R3 req_kind start", req_kind, 0);
      chk("R3 req_hub", req_hub, 7'h2A);
      chk("R3 req_port", req_port, 7'h05);
      chk("R3 ept control", req_ept, 2'b00);
      cfg_ctrl = 1'b0; cfg_speed = 2'b01;
      #1;
      chk("R3 ept bulk", req_ept, 2'b10);
      chk("R2 low-speed req_valid", req_valid, 1);
      cfg_speed = 2'b10;
      #1;
      chk("R2 high-speed no req", req_valid, 0);
      hs(1, 0, 0, 0, 1);
      state("R2 high-speed ignores strobes", 0, 3, 0, 0);
      cfg_speed = 2'b00;
      slot_go = 1'b0;
      #1;
      chk("R2 no slot no req", req_valid, 0);
   endtask

   task automatic t_start;
      hs(0, 1, 0, 0, 0);
      state("R4 start NAK", 0, 3, 0, 0);
      hs(0, 0, 0, 1, 0);
      state("R4 start STALL ignored", 0, 3, 0, 0);
      hs(0, 0, 1, 0, 0);
      state("R4 start NYET ignored", 0, 3, 0, 0);
      @(negedge clk);
      rsp_ack = 1'b1;
      #1;
      chk("R13 no change before edge", split_phase, 0);
      @(negedge clk);
      rsp_ack = 1'b0;
      state("R4 start ACK", 1, 3, 0, 0);
      slot_go = 1'b1;
      #1;
      chk("R3 req_kind complete", req_kind, 1);
      slot_go = 1'b0;
   endtask

   task automatic t_complete;
      hs(0, 0, 1, 0, 0);
      state("R7 complete NYET retry", 1, 3, 0, 0);
      chk("R7 no done on NYET", done, 0);
      hs(0, 0, 0, 0, 1);
      state("R9 complete xerr", 1, 2, 0, 1);
      hs(1, 0, 0, 0, 0);
      state("R10 complete ACK", 0, 2, 0, 1);
      chk("R10 done pulse", done, 1);
      @(negedge clk);
      chk("R10 done one cycle", done, 0);
      chk("R9 xact_err sticky", xact_err, 1);
      hs(1, 0, 0, 0, 0);
      hs(0, 1, 0, 0, 0);
      state("R10 complete NAK", 0, 2, 0, 1);
      chk("R10 no done on NAK", done, 0);
   endtask

   task automatic t_budget;
      init(2'd1);
      state("R1 init", 0, 1, 0, 0);
      hs(1, 0, 0, 0, 0);
      hs(0, 0, 0, 0, 1);
      state("R5 budget exhausted", 1, 0, 1, 1);
      slot_go = 1'b1;
      #1;
      chk("R11 halted no req", req_valid, 0);
      slot_go = 1'b0;
      hs(1, 0, 0, 0, 0);
      state("R11 halted ignores ACK", 1, 0, 1, 1);
      init(2'd3);
      state("R1 reinit", 0, 3, 0, 0);
      hs(0, 0, 0, 0, 1);
      state("R5 start xerr decrements", 0, 2, 0, 0);
   endtask

   task automatic t_stall;
      init(2'd3);
      hs(1, 0, 0, 0, 0);
      hs(0, 0, 0, 1, 0);
      state("R8 complete STALL", 1, 3, 1, 0);
   endtask

   task automatic t_unlimited;
      init(2'd0);
      for (int i = 0; i < 3; i++) hs(0, 0, 0, 0, 1);
      state("R6 zero budget no halt", 0, 0, 0, 0);
   endtask

   task automatic t_priority;
      init(2'd3);
      hs(1, 0, 0, 0, 1);
      state("R12 xerr over ACK", 0, 2, 0, 0);
      hs(1, 0, 0, 0, 0);
      hs(1, 0, 1, 0, 0);
      state("R12 NYET over ACK", 1, 2, 0, 0);
      chk("R12 no done", done, 0);
      hs(0, 0, 1, 1, 0);
      state("R12 STALL over NYET", 1, 2, 1, 0);
      init(2'd2);
      @(negedge clk);
      cfg_init = 1'b1; rsp_ack = 1'b1;
      @(negedge clk);
      cfg_init = 1'b0; rsp_ack = 1'b0;
      state("R1 init over ACK", 0, 2, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_request();
      t_start();
      t_complete();
      t_budget();
      t_stall();
      t_unlimited();
      t_priority();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule